// File: doc/BRIEF.md
# Shared-Node Thermal Sensor Readout Sequencer

This controller runs one conversion cycle for a bank of threshold-voltage temperature sensing frontends. The frontends share a single pre-charge switch, a single sampling node and a single sample-and-hold. A request carries the index of the frontend to read. The block then steps through three phases in a fixed order:

- **Pre-charge:** the shared switch fills the sampling node.
- **Sense:** the switch is released and only the chosen frontend is turned on. It discharges the node for a programmable number of clock cycles.
- **Hold:** the sample-and-hold is told to freeze the node voltage, and a done strobe marks the last cycle.

All gate drives are active low. Every frontend that is not being read, and every frontend while the block is idle, has its gate held at the supply level. This keeps idle devices from leaking onto the node and limits their aging stress. Phase lengths are given in system clock cycles. The sense length is limited to a legal window. With the default parameters at a 125 MHz clock, that window is 1 µs to 80 µs.

Top module: `thermal_readout_seq`

## Requirements
- R1: After reset and whenever idle: `preGateN`=1, every bit of `feGateN`=1, `shHold`=0 (sampling), `done`=0 and `idxError`=0.
- R2: An accepted request (`reqValid`=1 in idle with `reqIndex` < NUM_FE) starts pre-charge in the next cycle. Pre-charge lasts max(`cfgPreCycles`,1) cycles, with `preGateN`=0 and every bit of `feGateN`=1.
- R3: Sensing follows pre-charge directly. During sensing `preGateN`=1, and only bit `reqIndex` of `feGateN` is 0; all other bits are 1.
- R4: The sensing length is `cfgSenseCycles` limited to the range [SENSE_MIN, SENSE_MAX] (defaults 125 and 10000). Smaller values give SENSE_MIN and larger values give SENSE_MAX.
- R5: `shHold`=0 throughout pre-charge and sensing. `shHold`=1 for max(`cfgHoldCycles`,1) cycles starting in the cycle right after the last sensing cycle.
- R6: `done` is a one-cycle pulse in the final hold cycle. In the next cycle the block is idle as described in R1.
- R7: A request in idle with `reqIndex` ≥ NUM_FE starts no phase. `idxError`=1 for exactly the one cycle after that request.
- R8: While a cycle is in progress, `reqValid` is ignored, whatever its index. Phase lengths and the selected frontend stay unchanged, and `idxError` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Measurement request |
| reqIndex | input | IDX_W | Frontend to read (IDX_W = clog2(NUM_FE)+1) |
| cfgPreCycles | input | CNT_W | Pre-charge length in cycles |
| cfgSenseCycles | input | CNT_W | Requested sensing length in cycles |
| cfgHoldCycles | input | CNT_W | Hold length in cycles |
| preGateN | output | 1 | Pre-charge switch gate, 0 = on |
| feGateN | output | NUM_FE | Frontend gates, 0 = on |
| shHold | output | 1 | Sample-and-hold mode, 1 = hold |
| done | output | 1 | End-of-cycle strobe |
| idxError | output | 1 | Rejected out-of-range index |

## Verification
The hardest case to reach is a request that arrives while a cycle is already in progress. The design must drop it silently, and leave both the running phase lengths and the latched frontend selection unchanged. The stimulus raises `reqValid` during pre-charge with a different valid index, and again during sensing with an out-of-range index. It then measures each phase length from the gate outputs. It also checks that only the original frontend bit ever goes low, and that `idxError` never rises. The clamp bounds are reached by requesting sensing lengths below and above the legal window.

// File: rtl/thermseq_pkg.sv
package thermseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_SENSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadPre;
    logic loadSense;
    logic loadHold;
    logic latchSel;
    logic flagErr;
    logic preOn;
    logic senseOn;
    logic holdOn;
  } ctrl_strobe_t;

endpackage

// File: rtl/thermseq_ctrl.sv
module thermseq_ctrl
  import thermseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         idxOk,
  input  logic         phaseEnd,
  output ctrl_strobe_t strobe,
  output logic         done
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    done      = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid && idxOk) begin
          phaseNext       = PH_PRE;
          strobe.loadPre  = 1'b1;
          strobe.latchSel = 1'b1;
        end else if (reqValid) begin
          strobe.flagErr = 1'b1;
        end
      end
      PH_PRE: begin
        strobe.preOn = 1'b1;
        if (phaseEnd) begin
          phaseNext        = PH_SENSE;
          strobe.loadSense = 1'b1;
        end
      end
      PH_SENSE: begin
        strobe.senseOn = 1'b1;
        if (phaseEnd) begin
          phaseNext       = PH_HOLD;
          strobe.loadHold = 1'b1;
        end
      end
      PH_HOLD: begin
        strobe.holdOn = 1'b1;
        if (phaseEnd) begin
          phaseNext = PH_IDLE;
          done      = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/thermseq_datapath.sv
module thermseq_datapath
  import thermseq_pkg::*;
#(
  parameter int NUM_FE    = 8,
  parameter int CNT_W     = 16,
  parameter int SENSE_MIN = 125,
  parameter int SENSE_MAX = 10000,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [CNT_W-1:0]  cfgPreCycles,
  input  logic [CNT_W-1:0]  cfgSenseCycles,
  input  logic [CNT_W-1:0]  cfgHoldCycles,
  input  ctrl_strobe_t      strobe,
  output logic              idxOk,
  output logic              phaseEnd,
  output logic              preGateN,
  output logic [NUM_FE-1:0] feGateN,
  output logic              shHold,
  output logic              idxError
);

  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(SENSE_MIN);
  localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(SENSE_MAX);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  preLen, senseLen, holdLen;
  logic [NUM_FE-1:0] decodeHot, selHot;
  logic              errReg;

  assign idxOk = (32'(reqIndex) < NUM_FE);

  for (genvar g = 0; g < NUM_FE; g++) begin : g_decode
    assign decodeHot[g] = (reqIndex == IDX_W'(g));
  end

  assign preLen   = (cfgPreCycles  == '0) ? ONE : cfgPreCycles;
  assign holdLen  = (cfgHoldCycles == '0) ? ONE : cfgHoldCycles;
  assign senseLen = (cfgSenseCycles < MIN_LEN) ? MIN_LEN :
                    (cfgSenseCycles > MAX_LEN) ? MAX_LEN : cfgSenseCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      selHot   <= '0;
      errReg   <= 1'b0;
    end else begin
      errReg <= strobe.flagErr;
      if (strobe.latchSel) selHot <= decodeHot;
      if (strobe.loadPre)        phaseCnt <= preLen;
      else if (strobe.loadSense) phaseCnt <= senseLen;
      else if (strobe.loadHold)  phaseCnt <= holdLen;
      else if (phaseCnt != '0)   phaseCnt <= phaseCnt - ONE;
    end
  end

  assign phaseEnd = (phaseCnt == ONE);
  assign preGateN = ~strobe.preOn;
  assign feGateN  = strobe.senseOn ? ~selHot : '1;
  assign shHold   = strobe.holdOn;
  assign idxError = errReg;

endmodule

// File: rtl/thermal_readout_seq.sv
module thermal_readout_seq
  import thermseq_pkg::*;
#(
  parameter int NUM_FE    = 8,
  parameter int CNT_W     = 16,
  parameter int SENSE_MIN = 125,
  parameter int SENSE_MAX = 10000,
  localparam int IDX_W    = $clog2(NUM_FE) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [CNT_W-1:0]  cfgPreCycles,
  input  logic [CNT_W-1:0]  cfgSenseCycles,
  input  logic [CNT_W-1:0]  cfgHoldCycles,
  output logic              preGateN,
  output logic [NUM_FE-1:0] feGateN,
  output logic              shHold,
  output logic              done,
  output logic              idxError
);

  ctrl_strobe_t strobe;
  logic         idxOk;
  logic         phaseEnd;

  thermseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .idxOk    (idxOk),
    .phaseEnd (phaseEnd),
    .strobe   (strobe),
    .done     (done)
  );

  thermseq_datapath #(
    .NUM_FE    (NUM_FE),
    .CNT_W     (CNT_W),
    .SENSE_MIN (SENSE_MIN),
    .SENSE_MAX (SENSE_MAX),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .reqIndex       (reqIndex),
    .cfgPreCycles   (cfgPreCycles),
    .cfgSenseCycles (cfgSenseCycles),
    .cfgHoldCycles  (cfgHoldCycles),
    .strobe         (strobe),
    .idxOk          (idxOk),
    .phaseEnd       (phaseEnd),
    .preGateN       (preGateN),
    .feGateN        (feGateN),
    .shHold         (shHold),
    .idxError       (idxError)
  );

endmodule

// File: rtl/thermseq_checker.sv
module thermseq_checker #(
  parameter int NUM_FE    = 8,
  parameter int CNT_W     = 16,
  parameter int SENSE_MIN = 125,
  parameter int SENSE_MAX = 10000
) (
  input logic              clk,
  input logic              rstN,
  input logic              preGateN,
  input logic [NUM_FE-1:0] feGateN,
  input logic              shHold,
  input logic              done,
  input logic              idxError
);

  logic             anyOn;
  logic [CNT_W:0]   runCnt;
  logic [CNT_W:0]   lastLen;
  logic             lenValid;

  assign anyOn = ~(&feGateN);

  // measures each contiguous frontend-on window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      lastLen  <= '0;
      lenValid <= 1'b0;
    end else begin
      lenValid <= 1'b0;
      if (anyOn) begin
        runCnt <= runCnt + 1'b1;
      end else if (runCnt != '0) begin
        lastLen  <= runCnt;
        lenValid <= 1'b1;
        runCnt   <= '0;
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (preGateN && !anyOn && !shHold && !done));

  a_r2_fe_off_in_precharge: assert property (@(posedge clk) disable iff (!rstN)
    !preGateN |-> !anyOn);

  a_r3_single_frontend: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~feGateN));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    anyOn |-> preGateN);

  a_r4_sense_window: assert property (@(posedge clk) disable iff (!rstN)
    lenValid |-> (lastLen >= (CNT_W+1)'(SENSE_MIN) && lastLen <= (CNT_W+1)'(SENSE_MAX)));

  a_r5_sampling_while_active: assert property (@(posedge clk) disable iff (!rstN)
    (anyOn || !preGateN) |-> !shHold);

  a_r5_hold_follows_sense: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shHold) |-> $past(anyOn));

  a_r6_done_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    done |-> shHold);

  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (preGateN && !anyOn && !shHold && !done));

  a_r7_error_no_start: assert property (@(posedge clk) disable iff (!rstN)
    idxError |-> (preGateN && !anyOn && !shHold));

  a_r7_error_single: assert property (@(posedge clk) disable iff (!rstN)
    idxError |=> !idxError);

endmodule

bind thermal_readout_seq thermseq_checker #(
  .NUM_FE    (NUM_FE),
  .CNT_W     (CNT_W),
  .SENSE_MIN (SENSE_MIN),
  .SENSE_MAX (SENSE_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .preGateN (preGateN),
  .feGateN  (feGateN),
  .shHold   (shHold),
  .done     (done),
  .idxError (idxError)
);

// File: tb/sim_thermal_readout_seq.sv
`timescale 1ns/1ps
module sim_thermal_readout_seq;

  localparam int NUM_FE    = 8;
  localparam int CNT_W     = 16;
  localparam int SENSE_MIN = 125;
  localparam int SENSE_MAX = 10000;
  localparam int IDX_W     = $clog2(NUM_FE) + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [IDX_W-1:0]  reqIndex = '0;
  logic [CNT_W-1:0]  cfgPreCycles = '0;
  logic [CNT_W-1:0]  cfgSenseCycles = '0;
  logic [CNT_W-1:0]  cfgHoldCycles = '0;
  logic              preGateN;
  logic [NUM_FE-1:0] feGateN;
  logic              shHold;
  logic              done;
  logic              idxError;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  thermal_readout_seq #(
    .NUM_FE(NUM_FE), .CNT_W(CNT_W), .SENSE_MIN(SENSE_MIN), .SENSE_MAX(SENSE_MAX)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIndex(reqIndex),
    .cfgPreCycles(cfgPreCycles), .cfgSenseCycles(cfgSenseCycles),
    .cfgHoldCycles(cfgHoldCycles), .preGateN(preGateN), .feGateN(feGateN),
    .shHold(shHold), .done(done), .idxError(idxError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(preGateN == 1'b1, req, preGateN, 1);
    check(feGateN == '1, req, feGateN, (1 << NUM_FE) - 1);
    check(shHold == 1'b0, req, shHold, 0);
    check(done == 1'b0, req, done, 0);
  endtask

  // runs one readout cycle and measures every phase from the outputs
  task automatic runCycle(input int idx, input int pre, input int sense, input int hold,
                          input bit injectBusy);
    int expPre, expSense, expHold;
    int preCnt, senseCnt, holdCnt, doneCnt, cyc;
    bit orderBad, selBad, errSeen, finished;
    logic [NUM_FE-1:0] expGate;
    expPre   = (pre == 0) ? 1 : pre;
    expHold  = (hold == 0) ? 1 : hold;
    expSense = (sense < SENSE_MIN) ? SENSE_MIN : (sense > SENSE_MAX) ? SENSE_MAX : sense;
    expGate  = ~(NUM_FE'(1) << idx);
    preCnt = 0; senseCnt = 0; holdCnt = 0; doneCnt = 0; cyc = 0;
    orderBad = 0; selBad = 0; errSeen = 0; finished = 0;
    cfgPreCycles   = CNT_W'(pre);
    cfgSenseCycles = CNT_W'(sense);
    cfgHoldCycles  = CNT_W'(hold);
    @(negedge clk);
    reqValid = 1'b1;
    reqIndex = IDX_W'(idx);
    @(negedge clk);
    reqValid = 1'b0;
    while (!finished && cyc < 20000) begin
      if (!preGateN) begin
        if (feGateN != '1 || shHold || senseCnt != 0 || holdCnt != 0) orderBad = 1;
        preCnt++;
      end else if (feGateN != '1) begin
        if (feGateN != expGate) selBad = 1;
        if (shHold || holdCnt != 0) orderBad = 1;
        senseCnt++;
      end else if (shHold) begin
        holdCnt++;
      end
      if (idxError) errSeen = 1;
      if (done) begin
        doneCnt++;
        check(shHold && holdCnt == expHold, "R6 done in last hold cycle", holdCnt, expHold);
        @(negedge clk);
        checkIdle("R6 idle after done");
        check(!done, "R6 done single pulse", done, 0);
        finished = 1;
      end else begin
        reqValid = 1'b0;
        if (injectBusy && cyc == 0) begin
          reqValid = 1'b1; reqIndex = IDX_W'((idx + 1) % NUM_FE);
        end
        if (injectBusy && senseCnt == 3) begin
          reqValid = 1'b1; reqIndex = IDX_W'(NUM_FE + 1);
        end
        @(negedge clk);
        cyc++;
      end
    end
    reqValid = 1'b0;
    check(finished, "R6 cycle completes (watchdog)", cyc, expPre + expSense + expHold);
    check(preCnt == expPre, "R2 pre-charge length", preCnt, expPre);
    check(senseCnt == expSense, "R3/R4 sensing length", senseCnt, expSense);
    check(holdCnt == expHold, "R5 hold length", holdCnt, expHold);
    check(doneCnt == 1, "R6 done count", doneCnt, 1);
    check(!orderBad, "R5 phase order and sampling mode", orderBad, 0);
    check(!selBad, "R3 only selected frontend on", selBad, 0);
    if (injectBusy) check(!errSeen, "R8 busy request ignored, no error", errSeen, 0);
  endtask

  task automatic badIndex(input int idx);
    @(negedge clk);
    reqValid = 1'b1;
    reqIndex = IDX_W'(idx);
    @(negedge clk);
    reqValid = 1'b0;
    check(idxError == 1'b1, "R7 error flagged", idxError, 1);
    check(preGateN == 1'b1 && feGateN == '1, "R7 no cycle started", preGateN, 1);
    @(negedge clk);
    check(idxError == 1'b0, "R7 error one cycle", idxError, 0);
    checkIdle("R7 still idle");
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkIdle("R1 reset state");
    check(idxError == 1'b0, "R1 no error in reset", idxError, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 idle after reset");
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    runCycle(3, 4, 200, 3, 1'b0);
    runCycle(0, 0, 125, 0, 1'b0);
    runCycle(7, 2, 50, 2, 1'b0);      // R4 lower clamp
    runCycle(5, 2, 20000, 2, 1'b0);   // R4 upper clamp
    runCycle(2, 6, 300, 4, 1'b1);     // R8 ignored requests while busy
    badIndex(8);
    badIndex(15);
    runCycle(1, 1, 126, 1, 1'b0);     // back-to-back after error
    repeat (3) @(negedge clk);
    checkIdle("R1 idle at end");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule